// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block is the digital control core of a 16-bit successive-approximation converter. Two active-low control inputs, a chip select and a read/convert line, are combined into a single gate. A falling edge of that gate starts a conversion. A read is enabled when chip select is low and read/convert is high. Once a conversion starts, the sequencer clears its approximation register and makes one bit decision per clock, from the top bit down. Each decision comes from a comparator bit supplied from outside. A ready flag stays low for the whole conversion. The finished word is copied into an output latch before the flag rises again.

The output word is driven onto a parallel bus whose enable is a separate signal, so the tri-state buffer sits outside this block. A swap input can exchange the two byte halves of the bus, which lets a narrow host read the word in two passes. The analog sampler, the DAC and the comparator are outside the block. The sampler is told to hold through a plain control line.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, ready_o is 1, hold_o is 0, data_oe_o is 0 and data_o is all zeros.
- R2: With cs_n_i low, a falling edge of rdconv_i starts a conversion. ready_o drops three clock edges after the input change, because two synchroniser flops and one edge-detect flop lie on the path.
- R3: With rdconv_i low, a falling edge of cs_n_i starts a conversion. While cs_n_i is high, changes on rdconv_i start nothing.
- R4: The register is cleared at start and decided from bit 15 down to bit 0, one bit per clock. A comparator value of 1 keeps the trial bit and 0 clears it. The latched result is therefore the comparator sequence in the order it was given. The code is two's complement, with bit 15 as the sign.
- R5: ready_o is low for exactly 18 clock cycles per conversion, and hold_o is high whenever ready_o is low.
- R6: A start condition that arrives while a conversion is in progress is ignored. The result and the 18-cycle length are unchanged.
- R7: ready_o rises only after the output latch has been loaded, so data_o carries the new result in the first cycle that ready_o is high.
- R8: If the synchronised gate (chip select OR read/convert) is low when ready_o rises, a new conversion starts at once. ready_o is then high for a single cycle.
- R9: data_oe_o is 1 only when the synchronised chip select is low and the synchronised read/convert is high. It is 0 when chip select is high or when read/convert is low.
- R10: With swap_i low, data_o[15:8] is the result's high byte and data_o[7:0] its low byte. With swap_i high, the two bytes exchange places.
- R11: A read edge (a falling edge of cs_n_i with rdconv_i high, or a rising edge of rdconv_i with cs_n_i low) enables the bus and does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rdconv_i | input | 1 | Read (high) / convert (low), asynchronous |
| swap_i | input | 1 | Exchange the byte halves of data_o |
| cmp_i | input | 1 | Comparator decision for the current trial bit |
| ready_o | output | 1 | Low while a conversion is in progress |
| hold_o | output | 1 | Sampler hold command |
| data_o | output | 16 | Latched result, optionally byte-swapped |
| data_oe_o | output | 1 | Enable for the external tri-state bus buffer |

## Verification
A bit-index or state fault in the sequencer shows at the ports within one conversion. It appears either as a latched word that differs from the comparator sequence that was fed in, or as a ready-low window that is not 18 cycles long. A lost or spurious start shows as ready_o failing to drop, or dropping when it should not, three edges after the control inputs change. A wrong enable decode shows on data_oe_o two edges after the pins settle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAR_W = 16;
  localparam int unsigned IDX_W = $clog2(SAR_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_LATCH = 2'd2,
    ST_FIN   = 2'd3
  } sar_state_e;

  // One decision step: settle the current trial bit from the comparator,
  // then place the trial one on the next lower position.
  function automatic logic [SAR_W-1:0] sar_decide(
    input logic [SAR_W-1:0] cur,
    input logic [IDX_W-1:0] idx,
    input logic             keep
  );
    logic [SAR_W-1:0] nxt;
    nxt      = cur;
    nxt[idx] = keep;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
    return nxt;
  endfunction

  // Exchange the upper and lower halves of a word.
  function automatic logic [SAR_W-1:0] half_swap(input logic [SAR_W-1:0] w);
    return {w[SAR_W/2-1:0], w[SAR_W-1:SAR_W/2]};
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sar_evt.sv
module sar_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s_i,
  input  logic rc_s_i,
  output logic gate_fall_o,
  output logic gate_low_o,
  output logic oe_o
);
  logic gate;
  logic gate_q;

  // Chip select and read/convert are ORed; low gate means both low.
  assign gate = cs_s_i | rc_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate;
  end

  assign gate_fall_o = gate_q & ~gate;
  assign gate_low_o  = ~gate;
  assign oe_o        = ~cs_s_i & rc_s_i;
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req_i,
  input  logic             gate_low_i,
  input  logic             cmp_i,
  output logic             ready_o,
  output logic             hold_o,
  output logic             start_acc_o,
  output logic             latch_wr_o,
  output logic [SAR_W-1:0] result_o
);
  sar_state_e       state_q;
  logic [SAR_W-1:0] sar_q;
  logic [SAR_W-1:0] latch_q;
  logic [IDX_W-1:0] idx_q;
  logic             ready_q;
  logic             done_q;

  assign start_acc_o = (state_q == ST_IDLE) & (start_req_i | (done_q & gate_low_i));
  assign latch_wr_o  = (state_q == ST_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      latch_q <= '0;
      idx_q   <= '0;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_acc_o) begin
          state_q <= ST_CONV;
          sar_q   <= {1'b1, {(SAR_W-1){1'b0}}};
          idx_q   <= IDX_W'(SAR_W - 1);
          ready_q <= 1'b0;
        end
        ST_CONV: begin
          sar_q <= sar_decide(sar_q, idx_q, cmp_i);
          if (idx_q == '0) state_q <= ST_LATCH;
          else             idx_q   <= idx_q - 1'b1;
        end
        ST_LATCH: begin
          latch_q <= sar_q;
          state_q <= ST_FIN;
        end
        ST_FIN: begin
          ready_q <= 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o  = ready_q;
  assign hold_o   = (state_q != ST_IDLE);
  assign result_o = latch_q;

  // R6
  conv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && idx_q != '0) |=>
      (state_q == ST_CONV && idx_q == IDX_W'($past(idx_q) - 1'b1)));

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc_o |-> ready_q);

  // R7
  ready_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(latch_wr_o, 2));

  // R4
  conv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc_o |=> (sar_q == {1'b1, {(SAR_W-1){1'b0}}}));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic             rdconv_i,
  input  logic             swap_i,
  input  logic             cmp_i,
  output logic             ready_o,
  output logic             hold_o,
  output logic [SAR_W-1:0] data_o,
  output logic             data_oe_o
);
  logic             cs_s, rc_s;
  logic             gate_fall, gate_low;
  logic             start_acc, latch_wr;
  logic [SAR_W-1:0] result;

  sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_s));
  sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rc_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rdconv_i), .q_o(rc_s));

  sar_evt u_evt (
    .clk(clk), .rst_n(rst_n), .cs_s_i(cs_s), .rc_s_i(rc_s),
    .gate_fall_o(gate_fall), .gate_low_o(gate_low), .oe_o(data_oe_o));

  sar_core u_core (
    .clk(clk), .rst_n(rst_n), .start_req_i(gate_fall), .gate_low_i(gate_low),
    .cmp_i(cmp_i), .ready_o(ready_o), .hold_o(hold_o),
    .start_acc_o(start_acc), .latch_wr_o(latch_wr), .result_o(result));

  assign data_o = swap_i ? half_swap(result) : result;

  // R5
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> hold_o);

  // R9
  no_oe_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |-> !data_oe_o);

  // R2
  start_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_fall && ready_o) |=> !ready_o);

  // R7
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !latch_wr) |=> $stable(result));
endmodule

// File: tb/tb_sar_seq_top.sv
`timescale 1ns/1ps
module tb_sar_seq_top;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, rc, swap, cmp;
  logic        ready_o, hold_o, data_oe_o;
  logic [15:0] data_o;
  int          checks = 0;
  int          errors = 0;
  int          lc;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sar_seq_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .rdconv_i(rc), .swap_i(swap),
    .cmp_i(cmp), .ready_o(ready_o), .hold_o(hold_o), .data_o(data_o),
    .data_oe_o(data_oe_o));

  // {swap, comparator sequence}
  localparam logic [16:0] VEC [0:5] = '{
    {1'b0, 16'h7FFF}, {1'b1, 16'h8000}, {1'b0, 16'h0000},
    {1'b1, 16'hFFFF}, {1'b1, 16'h1234}, {1'b0, 16'hA5C3}};

  function automatic logic [15:0] expect_word(input logic [15:0] w, input logic s);
    return s ? {w[7:0], w[15:8]} : w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // rel: 0 keep pins, 1 raise rdconv, 2 raise chip select after start
  task automatic run_conv(input logic [15:0] t, input int rel, input bit glitch,
                          output int lowcnt);
    int guard = 0;
    while (ready_o && guard < 50) begin @(negedge clk); guard++; end
    chk(!ready_o, "R2 R3 start", 32'(ready_o), 0);
    chk(!data_oe_o, "R9 oe at start", 32'(data_oe_o), 0);
    lowcnt = 1;
    for (int i = 15; i >= 0; i--) begin
      cmp = t[i];
      if (i == 15 && rel == 1) rc = 1'b1;
      if (i == 15 && rel == 2) cs_n = 1'b1;
      if (glitch && i == 9) rc = 1'b0;
      if (glitch && i == 6) rc = 1'b1;
      @(negedge clk);
      if (!ready_o) lowcnt++;
    end
    guard = 0;
    while (!ready_o && guard < 10) begin
      @(negedge clk);
      if (!ready_o) lowcnt++;
      guard++;
    end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rc = 1'b1; swap = 1'b0; cmp = 1'b0;
    ticks(3);
    // R1
    chk(ready_o == 1'b1, "R1 ready", 32'(ready_o), 1);
    chk(hold_o == 1'b0, "R1 hold", 32'(hold_o), 0);
    chk(data_oe_o == 1'b0, "R1 oe", 32'(data_oe_o), 0);
    chk(data_o == 16'h0, "R1 data", 32'(data_o), 0);
    rst_n = 1'b1;
    ticks(2);

    // Table: rdconv-driven conversions (R2, R4, R5, R7, R9, R10)
    for (int v = 0; v < 6; v++) begin
      swap = VEC[v][16];
      cs_n = 1'b0; rc = 1'b1;
      ticks(3);
      rc = 1'b0;
      run_conv(VEC[v][15:0], 1, 1'b0, lc);
      chk(data_o == expect_word(VEC[v][15:0], swap), "R4 R7 R10 result",
          32'(data_o), 32'(expect_word(VEC[v][15:0], swap)));
      chk(lc == 18, "R5 low cycles", 32'(lc), 18);
      ticks(2);
      chk(data_oe_o == 1'b1, "R9 oe read", 32'(data_oe_o), 1);
      chk(ready_o == 1'b1, "R8 no restart", 32'(ready_o), 1);
      swap = ~swap;
      ticks(1);
      chk(data_o == expect_word(VEC[v][15:0], swap), "R10 swap toggle",
          32'(data_o), 32'(expect_word(VEC[v][15:0], swap)));
    end

    // R3: chip-select driven start; rdconv toggles with cs high do nothing
    swap = 1'b0;
    cs_n = 1'b1; rc = 1'b0;
    ticks(4);
    chk(ready_o == 1'b1, "R3 cs high no start", 32'(ready_o), 1);
    chk(data_oe_o == 1'b0, "R9 cs high", 32'(data_oe_o), 0);
    rc = 1'b1; ticks(3); rc = 1'b0; ticks(3);
    chk(ready_o == 1'b1, "R3 cs high rc fall", 32'(ready_o), 1);
    cs_n = 1'b0;
    run_conv(16'h4C2B, 2, 1'b0, lc);
    chk(data_o == 16'h4C2B, "R3 result", 32'(data_o), 32'h4C2B);
    chk(lc == 18, "R5 cs mode low", 32'(lc), 18);

    // R11: read edge via chip select with rdconv high
    rc = 1'b1; ticks(3);
    cs_n = 1'b0; ticks(3);
    chk(data_oe_o == 1'b1, "R11 oe on read", 32'(data_oe_o), 1);
    ticks(4);
    chk(ready_o == 1'b1, "R11 no conversion", 32'(ready_o), 1);
    chk(data_o == 16'h4C2B, "R11 data kept", 32'(data_o), 32'h4C2B);

    // R6: start condition during conversion is ignored
    rc = 1'b0;
    run_conv(16'h3E91, 1, 1'b1, lc);
    chk(data_o == 16'h3E91, "R6 result", 32'(data_o), 32'h3E91);
    chk(lc == 18, "R6 low cycles", 32'(lc), 18);
    ticks(4);
    chk(ready_o == 1'b1, "R6 no late start", 32'(ready_o), 1);

    // R8: both low when ready rises -> immediate restart
    ticks(2);
    rc = 1'b0;
    run_conv(16'h0F0F, 0, 1'b0, lc);
    chk(data_o == 16'h0F0F, "R8 first result", 32'(data_o), 32'h0F0F);
    ticks(1);
    chk(ready_o == 1'b0, "R8 restart", 32'(ready_o), 0);
    run_conv(16'hF00F, 1, 1'b0, lc);
    chk(data_o == 16'hF00F, "R8 second result", 32'(data_o), 32'hF00F);
    chk(lc == 18, "R8 second low", 32'(lc), 18);
    ticks(4);
    chk(ready_o == 1'b1, "R8 settles", 32'(ready_o), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule